// File: doc/BRIEF.md
# Serial Link Error Detection Unit

This unit sits beside a synchronous serial shift engine and watches each transfer for four faults: a slave clock that runs too fast or too slow against the programmed rate, input data that moves on the edge where it should be captured, a completed frame that lands on an unread receive buffer, and a slave-mode transfer that starts before software has refilled the transmit buffer. Each check has its own enable. Each fault sets a sticky flag that software clears with a per-bit clear strobe.

Receive and transmit faults raise a one-cycle error interrupt pulse. A clock-rate fault can also issue a one-cycle reset request to the shift engine when automatic reset is enabled. All inputs are plain level or single-cycle strobe pins in the system clock domain. No data stream crosses this block, so there is no valid/ready handshake and no back-pressure: every strobe is acted on in the cycle it is high.

Top module: `sserr_monitor`

## Requirements
- R1: A flag can be set only in a cycle where its enable input (`en_baud`, `en_phase`, `en_rx`, `en_tx`) is high. With the enable low, the same fault leaves the flag at 0.
- R2: In slave mode, a leading edge is the serial clock leaving its idle level `cpol`. The period is the number of system clocks between two successive leading edges. A baud fault is detected when the period is below `reload+1` or above `4*(reload+1)`. Both bounds themselves are accepted. The first leading edge after reset, after `frame_done` or after leaving slave mode only arms the measurement.
- R3: The sampling edge is the leading edge when `cpha`=1 and the trailing edge when `cpha`=0. A phase fault is detected when `din` at the sampling edge differs from its value one system clock earlier.
- R4: The receive buffer becomes full on `frame_done` and empty on `rbuf_read`. A receive fault is detected when `frame_done` arrives while the buffer is full and `rbuf_read` is low in that cycle.
- R5: The transmit buffer counts as fresh after `tbuf_write` and as consumed after `xfer_start`. It is not fresh after reset. A transmit fault is detected when `xfer_start` arrives in slave mode while the buffer is not fresh and `tbuf_write` is low. In master mode there is no transmit fault.
- R6: `err_irq` is a one-cycle pulse. It is high in the same cycle that the receive or transmit flag is set by a detected fault.
- R7: `reset_req` is a one-cycle pulse. It is high in the cycle that the baud flag is set by a fault, and only if `auto_rst_en` was high when the fault was detected.
- R8: Flags are sticky and sit at bit 0 baud, bit 1 phase, bit 2 receive, bit 3 transmit. `flag_clr` uses the same bit mapping. A detected fault wins over a clear in the same cycle. Flags, `err_irq` and `reset_req` update one system clock after the triggering input.
- R9: After reset, all flags, `err_irq` and `reset_req` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| slave_mode | input | 1 | 1 when the shift engine is a slave |
| cpol | input | 1 | Idle level of the serial clock |
| cpha | input | 1 | 1: sample on the leading edge; 0: sample on the trailing edge |
| reload | input | 13 | Programmed rate value; expected period is 2*(reload+1) |
| sclk_in | input | 1 | Serial clock |
| din | input | 1 | Serial data input |
| rbuf_read | input | 1 | Strobe: receive buffer read |
| tbuf_write | input | 1 | Strobe: transmit buffer written |
| xfer_start | input | 1 | Strobe: transfer begins |
| frame_done | input | 1 | Strobe: frame completed into the receive buffer |
| en_baud | input | 1 | Baud check enable |
| en_phase | input | 1 | Phase check enable |
| en_rx | input | 1 | Receive check enable |
| en_tx | input | 1 | Transmit check enable |
| auto_rst_en | input | 1 | Issue a reset request on a baud fault |
| flag_clr | input | 4 | Per-flag clear strobes |
| err_flags | output | 4 | Sticky fault flags |
| err_irq | output | 1 | Error interrupt pulse |
| reset_req | output | 1 | Engine reset request pulse |

## Verification
The clock-rate check is driven with periods of 2, 3, 4, 8, 16, 18 and 20 system clocks against a reload of 3. These show that both tolerance bounds are inclusive, that the first edge after disarming never compares, and that a fault pulses `reset_req` only when automatic reset is on. The phase check gets data moving on the leading edge and on the trailing edge under both `cpha` settings, which tells a sampling-edge transition from a harmless one. The buffer checks cover an unread buffer, a read in the same cycle as the frame, a refilled and a stale transmit buffer, master mode, a disabled check, and a clear that collides with a set.

// File: rtl/sserr_pkg.sv
package sserr_pkg;
  localparam int unsigned N_ERR     = 4;
  localparam int unsigned IDX_BAUD  = 0;
  localparam int unsigned IDX_PHASE = 1;
  localparam int unsigned IDX_RX    = 2;
  localparam int unsigned IDX_TX    = 3;
endpackage

// File: rtl/sserr_clk_watch.sv
module sserr_clk_watch #(
  parameter int unsigned RLD_W = 13
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             slave_mode,
  input  logic             cpol,
  input  logic             cpha,
  input  logic [RLD_W-1:0] reload,
  input  logic             sclk_in,
  input  logic             frame_done,
  output logic             sample_edge,
  output logic             baud_bad
);
  localparam int unsigned CNT_W = RLD_W + 3;
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic             sclk_q;
  logic             lead, trail;
  logic             armed;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] lo_lim, hi_lim;

  always_ff @(posedge clk) begin
    if (!rst_n) sclk_q <= 1'b0;
    else        sclk_q <= sclk_in;
  end

  assign lead        = (sclk_q == cpol) && (sclk_in != cpol);
  assign trail       = (sclk_q != cpol) && (sclk_in == cpol);
  assign sample_edge = cpha ? lead : trail;

  // period counter: restarts at each leading edge, saturates
  always_ff @(posedge clk) begin
    if (!rst_n)              cnt <= '0;
    else if (lead)           cnt <= CNT_W'(1);
    else if (cnt != CNT_MAX) cnt <= cnt + CNT_W'(1);
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                        armed <= 1'b0;
    else if (!slave_mode || frame_done) armed <= 1'b0;
    else if (lead)                     armed <= 1'b1;
  end

  assign lo_lim   = CNT_W'(reload) + CNT_W'(1);
  assign hi_lim   = lo_lim << 2;
  assign baud_bad = slave_mode && armed && lead && !frame_done &&
                    ((cnt < lo_lim) || (cnt > hi_lim));

  // R2: a leading edge in slave mode leaves the measurement armed
  p_arm_on_lead_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (lead && slave_mode && !frame_done) |=> armed);
endmodule

// File: rtl/sserr_buf_watch.sv
module sserr_buf_watch (
  input  logic clk,
  input  logic rst_n,
  input  logic slave_mode,
  input  logic rbuf_read,
  input  logic tbuf_write,
  input  logic xfer_start,
  input  logic frame_done,
  output logic rx_bad,
  output logic tx_bad
);
  logic rbuf_full;
  logic tbuf_fresh;

  always_ff @(posedge clk) begin
    if (!rst_n)          rbuf_full <= 1'b0;
    else if (frame_done) rbuf_full <= 1'b1;
    else if (rbuf_read)  rbuf_full <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)          tbuf_fresh <= 1'b0;
    else if (xfer_start) tbuf_fresh <= 1'b0;
    else if (tbuf_write) tbuf_fresh <= 1'b1;
  end

  assign rx_bad = frame_done && rbuf_full && !rbuf_read;
  assign tx_bad = slave_mode && xfer_start && !tbuf_fresh && !tbuf_write;

  p_full_after_frame_r4: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> rbuf_full);
  p_fresh_after_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (tbuf_write && !xfer_start) |=> tbuf_fresh);
endmodule

// File: rtl/sserr_sticky.sv
module sserr_sticky #(
  parameter int unsigned N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_req,
  input  logic [N-1:0] clr,
  output logic [N-1:0] flags
);
  for (genvar i = 0; i < N; i++) begin : g_flag
    always_ff @(posedge clk) begin
      if (!rst_n)          flags[i] <= 1'b0;
      else if (set_req[i]) flags[i] <= 1'b1;
      else if (clr[i])     flags[i] <= 1'b0;
    end

    p_set_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
      set_req[i] |=> flags[i]);
    p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (flags[i] && !clr[i]) |=> flags[i]);
  end
endmodule

// File: rtl/sserr_monitor.sv
module sserr_monitor
  import sserr_pkg::*;
#(
  parameter int unsigned RLD_W = 13
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             slave_mode,
  input  logic             cpol,
  input  logic             cpha,
  input  logic [RLD_W-1:0] reload,
  input  logic             sclk_in,
  input  logic             din,
  input  logic             rbuf_read,
  input  logic             tbuf_write,
  input  logic             xfer_start,
  input  logic             frame_done,
  input  logic             en_baud,
  input  logic             en_phase,
  input  logic             en_rx,
  input  logic             en_tx,
  input  logic             auto_rst_en,
  input  logic [N_ERR-1:0] flag_clr,
  output logic [N_ERR-1:0] err_flags,
  output logic             err_irq,
  output logic             reset_req
);
  logic             sample_edge, baud_bad, rx_bad, tx_bad;
  logic             din_q;
  logic [N_ERR-1:0] set_req;

  sserr_clk_watch #(.RLD_W(RLD_W)) u_clk (
    .clk(clk), .rst_n(rst_n), .slave_mode(slave_mode), .cpol(cpol),
    .cpha(cpha), .reload(reload), .sclk_in(sclk_in),
    .frame_done(frame_done), .sample_edge(sample_edge), .baud_bad(baud_bad)
  );

  sserr_buf_watch u_buf (
    .clk(clk), .rst_n(rst_n), .slave_mode(slave_mode),
    .rbuf_read(rbuf_read), .tbuf_write(tbuf_write),
    .xfer_start(xfer_start), .frame_done(frame_done),
    .rx_bad(rx_bad), .tx_bad(tx_bad)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) din_q <= 1'b0;
    else        din_q <= din;
  end

  always_comb begin
    set_req            = '0;
    set_req[IDX_BAUD]  = baud_bad && en_baud;
    set_req[IDX_PHASE] = sample_edge && (din != din_q) && en_phase;
    set_req[IDX_RX]    = rx_bad && en_rx;
    set_req[IDX_TX]    = tx_bad && en_tx;
  end

  sserr_sticky #(.N(N_ERR)) u_flags (
    .clk(clk), .rst_n(rst_n), .set_req(set_req), .clr(flag_clr),
    .flags(err_flags)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      err_irq   <= 1'b0;
      reset_req <= 1'b0;
    end else begin
      err_irq   <= set_req[IDX_RX] || set_req[IDX_TX];
      reset_req <= set_req[IDX_BAUD] && auto_rst_en;
    end
  end

  p_irq_src_r6: assert property (@(posedge clk) disable iff (!rst_n)
    err_irq |-> (err_flags[IDX_RX] || err_flags[IDX_TX]));
  p_rst_src_r7: assert property (@(posedge clk) disable iff (!rst_n)
    reset_req |-> (err_flags[IDX_BAUD] && $past(auto_rst_en)));
  p_gate_rx_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_flags[IDX_RX]) |-> $past(en_rx));
  p_gate_tx_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_flags[IDX_TX]) |-> $past(en_tx));
endmodule

// File: tb/sserr_monitor_bench.sv
module sserr_monitor_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        slave_mode = 1'b0, cpol = 1'b0, cpha = 1'b1;
  logic [12:0] reload = 13'd3;
  logic        sclk_in = 1'b0, din = 1'b0;
  logic        rbuf_read = 1'b0, tbuf_write = 1'b0, xfer_start = 1'b0, frame_done = 1'b0;
  logic        en_baud = 1'b0, en_phase = 1'b0, en_rx = 1'b0, en_tx = 1'b0, auto_rst_en = 1'b0;
  logic [3:0]  flag_clr = 4'b0;
  logic [3:0]  err_flags;
  logic        err_irq, reset_req;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  bit done = 0;

  typedef struct {
    int         due;
    logic [3:0] fl;
    logic       irq;
    logic       rr;
    string      tag;
  } exp_t;
  exp_t sb[$];

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  sserr_monitor u_sserr_monitor (
    .clk(clk), .rst_n(rst_n), .slave_mode(slave_mode), .cpol(cpol),
    .cpha(cpha), .reload(reload), .sclk_in(sclk_in), .din(din),
    .rbuf_read(rbuf_read), .tbuf_write(tbuf_write), .xfer_start(xfer_start),
    .frame_done(frame_done), .en_baud(en_baud), .en_phase(en_phase),
    .en_rx(en_rx), .en_tx(en_tx), .auto_rst_en(auto_rst_en),
    .flag_clr(flag_clr), .err_flags(err_flags), .err_irq(err_irq),
    .reset_req(reset_req)
  );

  // monitor: pops expectations when their cycle arrives
  always @(negedge clk) begin
    while (sb.size() > 0 && sb[0].due <= cyc) begin
      exp_t e;
      e = sb.pop_front();
      total++;
      if (e.due != cyc || err_flags !== e.fl || err_irq !== e.irq || reset_req !== e.rr) begin
        bad++;
        $display("FAIL %s: flags=%b irq=%b rr=%b expected flags=%b irq=%b rr=%b",
                 e.tag, err_flags, err_irq, reset_req, e.fl, e.irq, e.rr);
      end
    end
  end

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic expect_out(int off, logic [3:0] fl, logic irq, logic rr, string tag);
    sb.push_back('{cyc + off, fl, irq, rr, tag});
  endtask

  task automatic sclk_cycle(int hi, int lo);
    sclk_in = 1'b1;
    repeat (hi) tick();
    sclk_in = 1'b0;
    repeat (lo) tick();
  endtask

  task automatic pulse_frame();
    frame_done = 1'b1; tick(); frame_done = 1'b0;
  endtask

  task automatic clear_flags(logic [3:0] m, string tag);
    flag_clr = m;
    expect_out(1, err_flags & ~m, 1'b0, 1'b0, tag);
    tick();
    flag_clr = 4'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: run did not end, expected completion");
    finish_run();
  end

  initial begin
    repeat (3) tick();
    rst_n = 1'b1;
    expect_out(1, 4'b0000, 1'b0, 1'b0, "R9 reset state");
    tick(); tick();

    // ---- R2 / R7: clock-rate checks, reload=3 -> bounds 4..16
    slave_mode = 1'b1; en_baud = 1'b1; auto_rst_en = 1'b1;
    pulse_frame(); rbuf_read = 1'b1; tick(); rbuf_read = 1'b0;
    sclk_cycle(4, 4); sclk_cycle(4, 4); sclk_cycle(4, 4);
    expect_out(1, 4'b0000, 1'b0, 1'b0, "R2 nominal period 8");
    sclk_cycle(4, 4);

    pulse_frame();
    sclk_cycle(2, 2);
    expect_out(1, 4'b0000, 1'b0, 1'b0, "R2 lower bound period 4 accepted");
    sclk_cycle(8, 8);
    expect_out(1, 4'b0000, 1'b0, 1'b0, "R2 upper bound period 16 accepted");
    sclk_cycle(9, 9);
    expect_out(1, 4'b0001, 1'b0, 1'b1, "R2 R7 period 18 fault with reset request");
    expect_out(2, 4'b0001, 1'b0, 1'b0, "R7 reset request one cycle");
    sclk_cycle(2, 2);
    clear_flags(4'b0001, "R8 clear baud flag");

    pulse_frame();
    sclk_cycle(2, 2);
    sclk_cycle(2, 1);
    expect_out(1, 4'b0001, 1'b0, 1'b1, "R2 period 3 too short");
    sclk_cycle(2, 2);
    clear_flags(4'b0001, "R8 clear baud flag again");

    auto_rst_en = 1'b0;
    pulse_frame();
    sclk_cycle(2, 2); sclk_cycle(10, 10);
    expect_out(1, 4'b0001, 1'b0, 1'b0, "R7 period 20 fault without auto reset");
    sclk_cycle(1, 1);
    clear_flags(4'b0001, "R8 clear after long period");

    en_baud = 1'b0;
    pulse_frame();
    sclk_cycle(1, 1);
    expect_out(1, 4'b0000, 1'b0, 1'b0, "R1 baud check disabled");
    sclk_cycle(1, 1);
    rbuf_read = 1'b1; tick(); rbuf_read = 1'b0;

    // ---- R3: phase checks, cpol=0
    slave_mode = 1'b0; en_phase = 1'b1; cpha = 1'b1;
    tick();
    expect_out(1, 4'b0010, 1'b0, 1'b0, "R3 data moves on leading sampling edge");
    sclk_in = 1'b1; din = 1'b1; tick(); tick();
    clear_flags(4'b0010, "R8 clear phase flag");
    expect_out(1, 4'b0000, 1'b0, 1'b0, "R3 data moves on trailing edge ignored");
    sclk_in = 1'b0; din = 1'b0; tick(); tick();
    expect_out(1, 4'b0000, 1'b0, 1'b0, "R3 steady data on sampling edge");
    sclk_in = 1'b1; tick(); tick();
    cpha = 1'b0; tick();
    expect_out(1, 4'b0010, 1'b0, 1'b0, "R3 trailing sampling edge with cpha 0");
    sclk_in = 1'b0; din = 1'b1; tick(); tick();
    clear_flags(4'b0010, "R8 clear phase flag again");
    en_phase = 1'b0;
    sclk_in = 1'b1; tick(); tick();
    expect_out(1, 4'b0000, 1'b0, 1'b0, "R1 phase check disabled");
    sclk_in = 1'b0; din = 1'b0; tick(); tick();

    // ---- R4 / R6: receive overrun
    en_rx = 1'b1;
    expect_out(1, 4'b0000, 1'b0, 1'b0, "R4 first frame into empty buffer");
    pulse_frame();
    expect_out(1, 4'b0100, 1'b1, 1'b0, "R4 R6 overrun with interrupt");
    expect_out(2, 4'b0100, 1'b0, 1'b0, "R6 interrupt one cycle, flag sticky");
    pulse_frame(); tick();
    frame_done = 1'b1; flag_clr = 4'b0100;
    expect_out(1, 4'b0100, 1'b1, 1'b0, "R8 set wins over clear");
    tick(); frame_done = 1'b0; flag_clr = 4'b0;
    clear_flags(4'b0100, "R8 clear receive flag");
    frame_done = 1'b1; rbuf_read = 1'b1;
    expect_out(1, 4'b0000, 1'b0, 1'b0, "R4 read in same cycle as frame");
    tick(); frame_done = 1'b0; rbuf_read = 1'b0;
    en_rx = 1'b0;
    expect_out(1, 4'b0000, 1'b0, 1'b0, "R1 receive check disabled");
    pulse_frame(); tick();

    // ---- R5: transmit underrun
    slave_mode = 1'b1; en_tx = 1'b1;
    tbuf_write = 1'b1; tick(); tbuf_write = 1'b0;
    expect_out(1, 4'b0000, 1'b0, 1'b0, "R5 start after buffer written");
    xfer_start = 1'b1; tick(); xfer_start = 1'b0;
    expect_out(1, 4'b1000, 1'b1, 1'b0, "R5 R6 stale buffer underrun");
    expect_out(2, 4'b1000, 1'b0, 1'b0, "R6 interrupt one cycle on transmit");
    xfer_start = 1'b1; tick(); xfer_start = 1'b0; tick();
    clear_flags(4'b1000, "R8 clear transmit flag");
    slave_mode = 1'b0;
    expect_out(1, 4'b0000, 1'b0, 1'b0, "R5 master mode has no underrun");
    xfer_start = 1'b1; tick(); xfer_start = 1'b0;

    repeat (4) tick();
    if (sb.size() != 0) begin
      total++; bad++;
      $display("FAIL scoreboard: %0d items left, expected 0", sb.size());
    end
    finish_run();
  end
endmodule